// File: doc/BRIEF.md
# Memory access protection checker

This block sits beside a processor's memory bus and judges every strobed memory cycle against the attributes of the page being touched. Four independent sources can declare a cycle illegal: a mismatch between the key the processor presents and the key held for the page, an instruction fetch from a page that forbids execution, a data write to a page that the page table marks read-only, and a write to a page that a separate block-protection table marks read-only. The block-protection bit arrives from two tables: one for processor cycles and one for DMA cycles. The DMA acknowledge input picks between them, so a DMA engine can be allowed to write into regions that the processor may not write.

The page table and the address translation sit outside the block and present their results on input ports. The bus interface is reduced to a single data strobe. Any violation drives an active-low error output, which is registered and stays asserted while the strobe remains high. A second output reports on write cycles. A one-bit mode, loaded through a configuration write, selects one of two meanings for it: an active-low strobe that marks a legal write, or an active-high flag that marks a faulting write.

Top module: `mem_guard`

## Requirements
- R1: While and after reset, with no strobe, `prot_err_n` is 1, the write-status mode is the legal-write-strobe mode (0), and `wr_stat` is 1.
- R2: A clock edge with `strb` high and `key_cpu` different from `pg_key` drives `prot_err_n` to 0 after that edge. This applies to every cycle type and to DMA cycles.
- R3: A clock edge with `strb`, `cyc_fetch` and `pg_xp` all high drives `prot_err_n` to 0. The execute-protect bit alone never flags a cycle with `cyc_fetch` low.
- R4: A clock edge with `strb` high, `cyc_fetch` low, `cyc_wr` high and `pg_wp` high drives `prot_err_n` to 0.
- R5: A strobed data write (`cyc_fetch`=0, `cyc_wr`=1) with `dma_ack`=0 and `blk_wp_cpu`=1 drives `prot_err_n` to 0.
- R6: With `dma_ack`=1 the block-protection bit is taken from `blk_wp_dma` and `blk_wp_cpu` is ignored. With `dma_ack`=0, `blk_wp_dma` is ignored.
- R7: Data reads (`cyc_wr`=0) are never flagged by `pg_wp`, `blk_wp_cpu` or `blk_wp_dma`. A fetch with `cyc_wr` high counts as a fetch and is not flagged by those bits either.
- R8: Once `prot_err_n` is 0 it stays 0 for every following edge at which `strb` is high, even if the violating inputs go away. It returns to 1 after the first edge at which `strb` is low.
- R9: In mode 0, `wr_stat` is 0 after an edge exactly when `strb` is high, the cycle is a data write, no source reports a violation at that edge, and no error was latched before it. Otherwise `wr_stat` is 1.
- R10: In mode 1, `wr_stat` is 1 after an edge at which `strb` is high, the cycle is a data write, and a violation is reported at that edge or was flagged at an earlier edge of the same strobe. Otherwise `wr_stat` is 0.
- R11: At an edge with `cfg_we` high, the mode takes the value of `cfg_mode` (0 = legal-write strobe, 1 = fault flag), and the next output already uses the new mode. With `cfg_we` low the mode holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Loads the write-status mode |
| cfg_mode | input | 1 | New mode: 0 legal-write strobe, 1 fault flag |
| strb | input | 1 | Data strobe; high for the duration of a memory cycle |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = data cycle |
| cyc_wr | input | 1 | 1 = write, 0 = read (data cycles) |
| key_cpu | input | KEY_W | Access key presented by the processor |
| pg_key | input | KEY_W | Key stored for the addressed page |
| pg_xp | input | 1 | Page execute-protect bit |
| pg_wp | input | 1 | Page write-protect bit |
| blk_wp_cpu | input | 1 | Block-protection write-protect bit, processor table |
| blk_wp_dma | input | 1 | Block-protection write-protect bit, DMA table |
| dma_ack | input | 1 | DMA acknowledge; selects the DMA table |
| prot_err_n | output | 1 | Protection error, active low |
| wr_stat | output | 1 | Write status: legal-write strobe (low) or fault flag (high) |

## Verification
On every cycle the assertions check that each of the four violation sources pulls the error low at the next edge, and that the table selected by DMA acknowledge is the one that flags a write. They also check that a latched error persists while the strobe is high and clears once it drops, that mode 0 keeps the write-status pin high when idle, and that a configuration write lands in the mode. The bench scenarios are the only place that shows a bit having no effect: the unselected table during DMA and processor cycles, write-protect bits on reads, and execute-protect on data cycles. The scenarios also show the exact shape of the write-status pin in both modes, including a violation that appears part way through a write.

// File: rtl/mg_pkg.sv
package mg_pkg;

    localparam int NSRC     = 4;
    localparam int SRC_KEY  = 0;
    localparam int SRC_EXEC = 1;
    localparam int SRC_PWP  = 2;
    localparam int SRC_BWP  = 3;

    typedef enum logic {
        WS_STROBE = 1'b0,
        WS_FLAG   = 1'b1
    } ws_mode_e;

    typedef struct packed {
        logic     err;
        logic     wok;
        logic     wflt;
        ws_mode_e mode;
    } mg_state_t;

endpackage

// File: rtl/mg_tsel.sv
module mg_tsel #(
    parameter int NT = 2,
    localparam int SW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT-1:0] wp_tab,
    input  logic [SW-1:0] sel,
    output logic          wp_out
);
    always_comb begin
        wp_out = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (sel == SW'(i)) wp_out = wp_tab[i];
        end
    end
endmodule

// File: rtl/mg_viol.sv
module mg_viol
    import mg_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic [KEY_W-1:0] key_a,
    input  logic [KEY_W-1:0] key_p,
    input  logic             fetch,
    input  logic             wr,
    input  logic             xp,
    input  logic             pwp,
    input  logic             bwp,
    output logic [NSRC-1:0]  src
);
    logic dwr;

    always_comb begin
        dwr           = ~fetch & wr;
        src           = '0;
        src[SRC_KEY]  = (key_a != key_p);
        src[SRC_EXEC] = fetch & xp;
        src[SRC_PWP]  = dwr & pwp;
        src[SRC_BWP]  = dwr & bwp;
    end
endmodule

// File: rtl/mg_wstat.sv
module mg_wstat
    import mg_pkg::*;
(
    input  ws_mode_e mode,
    input  logic     wok,
    input  logic     wflt,
    output logic     pin
);
    always_comb begin
        unique case (mode)
            WS_STROBE: pin = ~wok;
            WS_FLAG:   pin = wflt;
            default:   pin = 1'b1;
        endcase
    end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
    import mg_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_mode,
    input  logic             strb,
    input  logic             cyc_fetch,
    input  logic             cyc_wr,
    input  logic [KEY_W-1:0] key_cpu,
    input  logic [KEY_W-1:0] pg_key,
    input  logic             pg_xp,
    input  logic             pg_wp,
    input  logic             blk_wp_cpu,
    input  logic             blk_wp_dma,
    input  logic             dma_ack,
    output logic             prot_err_n,
    output logic             wr_stat
);
    localparam int NT = 2;

    mg_state_t       st_d, st_q;
    logic            bwp_sel;
    logic [NSRC-1:0] src;
    logic            viol;
    logic            dwr;
    logic            mode_q;

    mg_tsel #(.NT(NT)) u_tsel (
        .wp_tab ({blk_wp_dma, blk_wp_cpu}),
        .sel    (dma_ack),
        .wp_out (bwp_sel)
    );

    mg_viol #(.KEY_W(KEY_W)) u_viol (
        .key_a (key_cpu),
        .key_p (pg_key),
        .fetch (cyc_fetch),
        .wr    (cyc_wr),
        .xp    (pg_xp),
        .pwp   (pg_wp),
        .bwp   (bwp_sel),
        .src   (src)
    );

    always_comb begin
        viol = |src;
        dwr  = ~cyc_fetch & cyc_wr;
        st_d = st_q;
        if (cfg_we) st_d.mode = ws_mode_e'(cfg_mode);
        st_d.err  = strb & (st_q.err | viol);
        st_d.wok  = strb & dwr & ~viol & ~st_q.err;
        st_d.wflt = strb & dwr & (viol | st_q.wflt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{err: 1'b0, wok: 1'b0, wflt: 1'b0, mode: WS_STROBE};
        end else begin
            st_q <= st_d;
        end
    end

    mg_wstat u_wstat (
        .mode (st_q.mode),
        .wok  (st_q.wok),
        .wflt (st_q.wflt),
        .pin  (wr_stat)
    );

    assign prot_err_n = ~st_q.err;
    assign mode_q     = st_q.mode;

endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
    parameter int KEY_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_mode,
    input logic             strb,
    input logic             cyc_fetch,
    input logic             cyc_wr,
    input logic [KEY_W-1:0] key_cpu,
    input logic [KEY_W-1:0] pg_key,
    input logic             pg_xp,
    input logic             pg_wp,
    input logic             blk_wp_cpu,
    input logic             blk_wp_dma,
    input logic             dma_ack,
    input logic             prot_err_n,
    input logic             wr_stat,
    input logic             mode_q
);
    assert_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && key_cpu != pg_key) |=> !prot_err_n);

    assert_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && cyc_fetch && pg_xp) |=> !prot_err_n);

    assert_pgwp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !cyc_fetch && cyc_wr && pg_wp) |=> !prot_err_n);

    assert_blkcpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !cyc_fetch && cyc_wr && !dma_ack && blk_wp_cpu) |=> !prot_err_n);

    assert_blkdma_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !cyc_fetch && cyc_wr && dma_ack && blk_wp_dma) |=> !prot_err_n);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !prot_err_n) |=> !prot_err_n);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strb |=> prot_err_n);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !cfg_we && !strb) |=> wr_stat);

    assert_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (mode_q == $past(cfg_mode)));
endmodule

bind mem_guard mem_guard_chk #(.KEY_W(KEY_W)) u_chk (.*);

// File: tb/sim_mem_guard.sv
`timescale 1ns/1ps
module sim_mem_guard;
    localparam int KW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_mode = 1'b0;
    logic          strb = 1'b0, cyc_fetch = 1'b0, cyc_wr = 1'b0;
    logic [KW-1:0] key_cpu = '0, pg_key = '0;
    logic          pg_xp = 1'b0, pg_wp = 1'b0;
    logic          blk_wp_cpu = 1'b0, blk_wp_dma = 1'b0, dma_ack = 1'b0;
    logic          prot_err_n, wr_stat;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // behavioural reference state
    int m_err = 0, m_ok = 0, m_flt = 0, m_mode = 0;

    always #2 clk = ~clk;

    mem_guard #(.KEY_W(KW)) u0 (
        .clk, .rst_n, .cfg_we, .cfg_mode, .strb, .cyc_fetch, .cyc_wr,
        .key_cpu, .pg_key, .pg_xp, .pg_wp, .blk_wp_cpu, .blk_wp_dma,
        .dma_ack, .prot_err_n, .wr_stat
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        int exp_ws;
        exp_ws = (m_mode == 0) ? (m_ok ? 0 : 1) : (m_flt ? 1 : 0);
        check(tag, int'(prot_err_n), m_err ? 0 : 1, "prot_err_n");
        check(tag, int'(wr_stat), exp_ws, "wr_stat");
    endtask

    task automatic model_edge();
        int v, w, bw;
        w  = (!cyc_fetch && cyc_wr) ? 1 : 0;
        bw = dma_ack ? int'(blk_wp_dma) : int'(blk_wp_cpu);
        v  = 0;
        if (key_cpu != pg_key) v = 1;
        if (cyc_fetch && pg_xp) v = 1;
        if (w && (pg_wp || bw)) v = 1;
        if (cfg_we) m_mode = int'(cfg_mode);
        m_ok  = (strb && w && !v && !m_err) ? 1 : 0;
        m_flt = (strb && w && (v || m_flt)) ? 1 : 0;
        m_err = (strb && (m_err || v)) ? 1 : 0;
    endtask

    // one clock: inputs already set at the negedge; compare at next negedge
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        strb = 0; cyc_fetch = 0; cyc_wr = 0; cfg_we = 0;
        key_cpu = 4'h3; pg_key = 4'h3;
        pg_xp = 0; pg_wp = 0; blk_wp_cpu = 0; blk_wp_dma = 0; dma_ack = 0;
        step(tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL R0 watchdog expired actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1;
        idle("R1");
        idle("R1");

        // R2: key mismatch on a read, held then released (R8)
        strb = 1; key_cpu = 4'h5; pg_key = 4'h6;
        step("R2");
        key_cpu = 4'h6;
        step("R8");
        step("R8");
        idle("R8");
        idle("R8");

        // R3: fetch from execute-protected page
        strb = 1; cyc_fetch = 1; pg_xp = 1;
        step("R3"); step("R3");
        idle("R3");
        // R3: execute-protect ignored on data read
        strb = 1; cyc_fetch = 0; pg_xp = 1;
        step("R3"); step("R3");
        idle("R3");

        // R4: data write to write-protected page
        strb = 1; cyc_wr = 1; pg_wp = 1;
        step("R4"); step("R4");
        idle("R4");
        // R7: read from write-protected page, both tables set
        strb = 1; cyc_wr = 0; pg_wp = 1; blk_wp_cpu = 1; blk_wp_dma = 1;
        step("R7"); step("R7");
        idle("R7");
        // R7: fetch with write high on protected page
        strb = 1; cyc_fetch = 1; cyc_wr = 1; pg_wp = 1; blk_wp_cpu = 1;
        step("R7");
        idle("R7");

        // R5: processor block protection
        strb = 1; cyc_wr = 1; blk_wp_cpu = 1;
        step("R5"); step("R5");
        idle("R5");
        // R6: DMA ignores processor table
        strb = 1; cyc_wr = 1; blk_wp_cpu = 1; dma_ack = 1;
        step("R6"); step("R6");
        idle("R6");
        // R6: DMA table flags DMA write
        strb = 1; cyc_wr = 1; blk_wp_dma = 1; dma_ack = 1;
        step("R6");
        idle("R6");
        // R6: processor ignores DMA table
        strb = 1; cyc_wr = 1; blk_wp_dma = 1; dma_ack = 0;
        step("R6");
        idle("R6");

        // R9: legal write strobe, then violation mid-cycle
        strb = 1; cyc_wr = 1;
        step("R9"); step("R9");
        pg_wp = 1;
        step("R9");
        pg_wp = 0;
        step("R9");
        idle("R9");

        // R11: switch to flag mode
        cfg_we = 1; cfg_mode = 1;
        step("R11");
        cfg_we = 0;
        // R10: legal write gives low, faulting write high and held
        strb = 1; cyc_wr = 1;
        step("R10");
        key_cpu = 4'h1;
        step("R10");
        key_cpu = 4'h3;
        step("R10");
        idle("R10");
        // R11: back to strobe mode while a legal write runs
        strb = 1; cyc_wr = 1; cfg_we = 1; cfg_mode = 0;
        step("R11");
        cfg_we = 0;
        step("R11");
        idle("R11");

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            strb       = ($urandom_range(0, 3) != 0);
            cyc_fetch  = $urandom_range(0, 1);
            cyc_wr     = $urandom_range(0, 1);
            key_cpu    = 4'h3;
            pg_key     = ($urandom_range(0, 7) == 0) ? 4'h4 : 4'h3;
            pg_xp      = ($urandom_range(0, 5) == 0);
            pg_wp      = ($urandom_range(0, 5) == 0);
            blk_wp_cpu = ($urandom_range(0, 4) == 0);
            blk_wp_dma = ($urandom_range(0, 4) == 0);
            dma_ack    = $urandom_range(0, 1);
            cfg_we     = ($urandom_range(0, 30) == 0);
            cfg_mode   = $urandom_range(0, 1);
            step(m_mode ? "R10" : "R9");
        end
        idle("R8");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule